// File: doc/BRIEF.md
# Twelve-Pin GPIO Port with Chip-Select Sharing

This block controls twelve general purpose pins from two configuration registers on a simple register bus. For every pin it stores a direction bit, a pull-up enable bit and a data bit. From these it drives three per-pin pad controls: an output enable, an output value and a pull-up enable. It reads the pin level back from the pad.

Six of the pins can also carry a serial chip select. Pins 0 to 4 carry the five selects of the expansion serial master. Pin 11 carries the single select of the boot serial master. While a master is active, the level on its pin is the AND of the chip select and the pin's data bit. Software therefore sets such a pin as an output holding 1, so that the chip select can pull it low. The serial engines, the pad and the resistor itself are outside this block.

Register 0 is the configuration register: direction in bits [11:0], where 1 means output, and pull-up enables in bits [27:16]. Register 1 is the data register. Writing it sets the output data bits [11:0]. Reading it returns the synchronized pin levels.

Top module: `gpio_cs_port`

## Requirements
- R1: While reset is asserted and after it is released, every output enable is 0, every pull-up enable is 1, and register 0 reads 0x0FFF0000.
- R2: A write to register 0 (reg_addr_i = 0) sets pin_oe_o to wdata[11:0] from the clock edge that takes the write. Register 0 reads that value back in [11:0].
- R3: A write to register 0 stores the pull-up enables from wdata[27:16]. A pin that is an input, or that is driven high, presents its stored pull bit on pin_pu_o. Register 0 reads the pull bits back in [27:16].
- R4: Reading register 1 returns pin_i in [11:0] after a two-flop synchronizer. A level applied before clock edge k is readable after edge k+1. The stored data bits are never returned.
- R5: Any pin that is an output and drives 0 has pin_pu_o = 0, whatever its pull bit holds.
- R6: A pin that is an output with data bit 1 drives pin_out_o = 1 when no chip select pulls it low.
- R7: While grp_mst_i = 1, pin_out_o[k] = data[k] AND grp_cs_i[k] for k = 0..4.
- R8: While boot_mst_i = 1, pin_out_o[11] = data[11] AND boot_cs_i.
- R9: While a master input is 0, its chip-select inputs have no effect, and its pins output their plain data bits.
- R10: Unused read bits are zero: [15:12] and [31:28] of register 0, and [31:12] of register 1.
- R11: Pins 5 to 10 output their data bits regardless of any master or chip-select input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 configuration, 1 data |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| pin_i | input | 12 | Sampled pad levels |
| pin_oe_o | output | 12 | Per-pin output enable |
| pin_out_o | output | 12 | Per-pin output value |
| pin_pu_o | output | 12 | Per-pin pull-up enable |
| grp_mst_i | input | 1 | Expansion serial master active |
| grp_cs_i | input | 5 | Expansion serial chip selects for pins 0 to 4 |
| boot_mst_i | input | 1 | Boot serial master active |
| boot_cs_i | input | 1 | Boot serial chip select for pin 11 |

## Verification
The hardest case to reach is a pin that is an output with data 1 while its chip select is low. The pin must then drive 0 and drop its pull-up, even though the stored bits ask for a high level with pull-up. The bench reaches this case by writing register patterns whose direction, pull and data bits differ from pin to pin. For each pattern it sweeps both master enables and all 64 chip-select combinations, and it compares every pad output against a model computed in the bench. A separate sequence drives pin levels that differ from the stored data, which shows both the two-clock read latency and that the read returns pin levels rather than the stored bits.

// File: rtl/gpio_cs_pkg.sv
package gpio_cs_pkg;
  localparam int unsigned NPINS   = 12;
  localparam int unsigned RW      = 32;
  localparam int unsigned PU_LSB  = 16;
  localparam int unsigned CSG_NUM = 5;
  localparam int unsigned CSB_PIN = 11;

  typedef enum logic {
    SEL_CFG = 1'b0,
    SEL_DAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gpio_cs_regs.sv
module gpio_cs_regs #(
  parameter int unsigned N      = gpio_cs_pkg::NPINS,
  parameter int unsigned DW     = gpio_cs_pkg::RW,
  parameter int unsigned PU_LSB = gpio_cs_pkg::PU_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  dir_o,
  output logic [N-1:0]  pull_o,
  output logic [N-1:0]  data_o
);
  import gpio_cs_pkg::*;

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[PU_LSB-1:N], wdata_i[DW-1:PU_LSB+N]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      pull_o <= '1;
      data_o <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_CFG) begin
        dir_o  <= wdata_i[N-1:0];
        pull_o <= wdata_i[PU_LSB+N-1:PU_LSB];
      end else begin
        data_o <= wdata_i[N-1:0];
      end
    end
  end
endmodule

// File: rtl/gpio_cs_sync.sv
module gpio_cs_sync #(
  parameter int unsigned N      = gpio_cs_pkg::NPINS,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pin_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cs_pin_mux.sv
module gpio_cs_pin_mux #(
  parameter int unsigned N       = gpio_cs_pkg::NPINS,
  parameter int unsigned CSG_NUM = gpio_cs_pkg::CSG_NUM,
  parameter int unsigned CSB_PIN = gpio_cs_pkg::CSB_PIN
) (
  input  logic [N-1:0]       dir_i,
  input  logic [N-1:0]       pull_i,
  input  logic [N-1:0]       data_i,
  input  logic               grp_mst_i,
  input  logic [CSG_NUM-1:0] grp_cs_i,
  input  logic               boot_mst_i,
  input  logic               boot_cs_i,
  output logic [N-1:0]       oe_o,
  output logic [N-1:0]       out_o,
  output logic [N-1:0]       pu_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic cs;
    // idle or non-master select acts as 1 in the AND
    if (i < CSG_NUM) begin : g_grp
      assign cs = grp_mst_i ? grp_cs_i[i] : 1'b1;
    end else if (i == CSB_PIN) begin : g_boot
      assign cs = boot_mst_i ? boot_cs_i : 1'b1;
    end else begin : g_plain
      assign cs = 1'b1;
    end
    assign oe_o[i]  = dir_i[i];
    assign out_o[i] = data_i[i] & cs;
    // pull-up dropped whenever the pin actively drives low
    assign pu_o[i]  = pull_i[i] & ~(dir_i[i] & ~out_o[i]);
  end
endmodule

// File: rtl/gpio_cs_port.sv
module gpio_cs_port #(
  parameter int unsigned N       = gpio_cs_pkg::NPINS,
  parameter int unsigned DW      = gpio_cs_pkg::RW,
  parameter int unsigned PU_LSB  = gpio_cs_pkg::PU_LSB,
  parameter int unsigned CSG_NUM = gpio_cs_pkg::CSG_NUM,
  parameter int unsigned CSB_PIN = gpio_cs_pkg::CSB_PIN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [N-1:0]       pin_i,
  output logic [N-1:0]       pin_oe_o,
  output logic [N-1:0]       pin_out_o,
  output logic [N-1:0]       pin_pu_o,
  input  logic               grp_mst_i,
  input  logic [CSG_NUM-1:0] grp_cs_i,
  input  logic               boot_mst_i,
  input  logic               boot_cs_i
);
  import gpio_cs_pkg::*;

  logic [N-1:0] dir, pull, data, pin_sync;

  gpio_cs_regs #(.N(N), .DW(DW), .PU_LSB(PU_LSB)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .dir_o   (dir),
    .pull_o  (pull),
    .data_o  (data)
  );

  gpio_cs_sync #(.N(N), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pin_o  (pin_sync)
  );

  gpio_cs_pin_mux #(.N(N), .CSG_NUM(CSG_NUM), .CSB_PIN(CSB_PIN)) u_mux (
    .dir_i      (dir),
    .pull_i     (pull),
    .data_i     (data),
    .grp_mst_i  (grp_mst_i),
    .grp_cs_i   (grp_cs_i),
    .boot_mst_i (boot_mst_i),
    .boot_cs_i  (boot_cs_i),
    .oe_o       (pin_oe_o),
    .out_o      (pin_out_o),
    .pu_o       (pin_pu_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == SEL_CFG) begin
      reg_rdata_o[N-1:0]               = dir;
      reg_rdata_o[PU_LSB+N-1:PU_LSB]   = pull;
    end else begin
      reg_rdata_o[N-1:0]               = pin_sync;
    end
  end
endmodule

// File: rtl/gpio_cs_port_chk.sv
module gpio_cs_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic [11:0] pin_i,
  input logic [11:0] pin_oe_o,
  input logic [11:0] pin_out_o,
  input logic [11:0] pin_pu_o,
  input logic        grp_mst_i,
  input logic [4:0]  grp_cs_i,
  input logic        boot_mst_i,
  input logic        boot_cs_i
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (pin_oe_o == '0 && pin_pu_o == '1)
        else $error("R1 reset state");
    end
  end

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=> (pin_oe_o == $past(reg_wdata_i[11:0])));

  a_r3_pull_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=>
      ((pin_pu_o & ~pin_oe_o) == ($past(reg_wdata_i[27:16]) & ~pin_oe_o)));

  a_r4_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2 && reg_addr_i) |-> (reg_rdata_o[11:0] == $past(pin_i, 2)));

  a_r5_low_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~pin_out_o & pin_pu_o) == 12'h000));

  a_r7_grp_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_mst_i |-> ((pin_out_o[4:0] & ~grp_cs_i) == 5'h00));

  a_r8_boot_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_mst_i && !boot_cs_i) |-> !pin_out_o[11]);

  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i ? (reg_rdata_o[31:12] == '0)
               : (reg_rdata_o[15:12] == '0 && reg_rdata_o[31:28] == '0));
endmodule

bind gpio_cs_port gpio_cs_port_chk u_chk (.*);

// File: tb/tb_gpio_cs_port.sv
`timescale 1ns/1ps
module tb_gpio_cs_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [11:0] pin_i = '0;
  logic [11:0] pin_oe_o, pin_out_o, pin_pu_o;
  logic        grp_mst_i = 1'b0;
  logic [4:0]  grp_cs_i = '1;
  logic        boot_mst_i = 1'b0;
  logic        boot_cs_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_cs_port dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic logic [11:0] model_out(logic [11:0] d, logic gm, logic [4:0] gc,
                                            logic bm, logic bc);
    logic [11:0] cs = '1;
    if (gm) cs[4:0] = gc;
    if (bm) cs[11] = bc;
    return d & cs;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] dir, pull, dat, eo, ep;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 oe in reset", {20'h0, pin_oe_o}, 32'h0);
    chk("R1 pu in reset", {20'h0, pin_pu_o}, 32'hFFF);
    rst_ni = 1'b1;
    @(negedge clk_i);
    reg_addr_i = 1'b0;
    #0.5 chk("R1 cfg readback", reg_rdata_o, 32'h0FFF_0000);
    chk("R1 oe after reset", {20'h0, pin_oe_o}, 32'h0);

    // R6 / R5 directed
    wr(1'b0, 32'h0000_0FFF);
    wr(1'b1, 32'hFFFF_FFFF);
    #0.5 chk("R6 drive high", {20'h0, pin_out_o}, 32'hFFF);
    chk("R6 pu unaffected", {20'h0, pin_pu_o}, 32'h000);
    wr(1'b0, 32'h0FFF_0FFF);
    wr(1'b1, 32'h0000_0000);
    #0.5 chk("R5 drive low", {20'h0, pin_out_o}, 32'h000);
    chk("R5 pull forced off", {20'h0, pin_pu_o}, 32'h000);
    wr(1'b1, 32'h0000_0FFF);
    #0.5 chk("R3 pull kept when high", {20'h0, pin_pu_o}, 32'hFFF);

    // R4 synchronizer latency; stored data (0xFFF) differs from pins
    wr(1'b1, 32'h0000_0FFF);
    reg_addr_i = 1'b1;
    pin_i = 12'h000;
    repeat (3) @(negedge clk_i);
    pin_i = 12'hA5C;
    @(negedge clk_i);
    chk("R4 one edge old", reg_rdata_o, 32'h0);
    @(negedge clk_i);
    chk("R4 two edges new", reg_rdata_o, 32'h0000_0A5C);
    pin_i = 12'h3C1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R4 pins not data", reg_rdata_o, 32'h0000_03C1);
    chk("R10 dat unused zero", {reg_rdata_o[31:12], 12'h0}, 32'h0);

    // sweep
    for (int p = 0; p < 24; p++) begin
      dir  = 12'(p * 1237 + 3);
      pull = 12'(p * 2731 + 5);
      dat  = 12'(p * 3343 + 165);
      wr(1'b0, {4'hF, pull, 4'hF, dir});
      wr(1'b1, {20'hFFFFF, dat});
      reg_addr_i = 1'b0;
      #0.5 chk("R2 dir readback", {20'h0, reg_rdata_o[11:0]}, {20'h0, dir});
      chk("R3 pull readback", {20'h0, reg_rdata_o[27:16]}, {20'h0, pull});
      chk("R10 cfg unused zero", {16'h0, reg_rdata_o[31:28], 8'h0, reg_rdata_o[15:12]},
          32'h0);
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 64; c++) begin
          grp_mst_i = m[0]; boot_mst_i = m[1];
          grp_cs_i = c[4:0]; boot_cs_i = c[5];
          #0.1;
          eo = model_out(dat, m[0], c[4:0], m[1], c[5]);
          ep = pull & ~(dir & ~eo);
          chk("R2 oe", {20'h0, pin_oe_o}, {20'h0, dir});
          if (m[0]) chk("R7 grp pins", {27'h0, pin_out_o[4:0]}, {27'h0, eo[4:0]});
          else      chk("R9 grp idle", {27'h0, pin_out_o[4:0]}, {27'h0, dat[4:0]});
          if (m[1]) chk("R8 boot pin", {31'h0, pin_out_o[11]}, {31'h0, eo[11]});
          else      chk("R9 boot idle", {31'h0, pin_out_o[11]}, {31'h0, dat[11]});
          chk("R11 plain pins", {26'h0, pin_out_o[10:5]}, {26'h0, dat[10:5]});
          chk("R5 pull rule", {20'h0, pin_pu_o}, {20'h0, ep});
        end
      end
      grp_mst_i = 1'b0; boot_mst_i = 1'b0;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule